// File: doc/BRIEF.md
# Buffered 16-bit Free-Running Timer with Input Capture

This peripheral keeps a 16-bit up-counter that runs freely from one of two sources: an internal clock divided by a fixed ratio, or an external clock pin. It sits on an 8-bit register bus. Software reads or writes the 16-bit counter as two byte accesses. A hidden staging byte makes each pair of accesses behave as one coherent 16-bit transfer, provided the upper byte is accessed first.

One capture channel watches a capture pin. On the selected edge, it copies the counter into a capture register and raises a sticky flag. The external clock pin and the capture pin are asynchronous. Each passes through a two-flop synchronizer and an edge detector, so every qualifying edge acts exactly once. A counter wrap from all-ones to zero sets a sticky overflow flag.

The register bus has no back-pressure. A read or write strobe is accepted on the clock edge where it is high. Read data is combinational and is valid while the read strobe is high. Register indices: 0 counter upper, 1 counter lower, 2 capture upper, 3 capture lower, 4 control.

Top module: `frt16_bytebus`

## Requirements
- R1: After reset, the counter, the capture register, the staging byte and the control register are all zero. This selects the internal source and falling-edge capture, with both flags clear.
- R2: A read of index 0 returns the live upper counter byte and, on that edge, copies the live lower byte into the staging byte. A read of index 1 returns the staging byte, not the live counter.
- R3: A write to index 0 stores the data only in the staging byte and leaves the counter unchanged.
- R4: A write to index 1 loads the whole counter in one edge: the upper half comes from the staging byte and the lower half from the written data.
- R5: With control bit 0 = 0, the counter advances once every PRESC_DIV clocks (default 4). A write to index 1 restarts the divider phase, so the counter holds the written value K and reads K+n exactly 4n clocks after the write edge.
- R6: With control bit 0 = 1, the counter advances once per rising edge of the external clock pin whose high and low phases each last at least 2 system clocks. Otherwise it holds.
- R7: An advance from 0xFFFF gives 0x0000 and sets the overflow flag (control bit 2). Writing 0 to bit 2 clears the flag. Writing 1 to bit 2 has no effect.
- R8: Control bit 1 selects the capture edge: 1 for rising, 0 for falling. On the selected edge of the capture pin, the capture register loads the counter and the capture flag sets. The flag appears on the cap_flag pin and as control bit 3. The opposite edge captures nothing.
- R9: A read of index 2 returns the upper capture byte and copies the lower capture byte into the same staging byte. Index 3 returns the staging byte.
- R10: Writes to indices 2 and 3 have no effect on the capture register.
- R11: The capture flag stays set until a control write with bit 3 = 0. A control write with bit 3 = 1 leaves it set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register index |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one access per high cycle |
| bus_rd | input | 1 | Read strobe, one access per high cycle |
| bus_rdata | output | 8 | Read data, zero when bus_rd is low |
| ext_clk_pin | input | 1 | Asynchronous external count clock |
| cap_pin | input | 1 | Asynchronous capture input |
| cap_flag | output | 1 | Sticky capture flag |

## Verification
The assertions check these behaviours on every cycle:
- an upper-byte write leaves the counter alone;
- a lower-byte write loads the 16-bit value from the staging byte and the data;
- an upper-byte read snapshots the lower half;
- a wrap lands on zero with the overflow flag set;
- a capture event leaves the flag set and the register equal to the counter;
- synchronized edges and internal ticks never fire on two adjacent cycles.

Only the bench scenarios can show the following:
- software-visible coherence, where the lower byte read after external counting differs from the live counter;
- exact pulse counting from the external pin;
- the divider phase after a write;
- edge selectivity of the capture;
- the way control writes of 0 and 1 treat each flag.

// File: rtl/frt_pkg.sv
package frt_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_CNT_HI = 3'd0,
    REG_CNT_LO = 3'd1,
    REG_CAP_HI = 3'd2,
    REG_CAP_LO = 3'd3,
    REG_CTRL   = 3'd4
  } frt_reg_e;

  localparam int unsigned CTRL_SRC_BIT  = 0;
  localparam int unsigned CTRL_EDGE_BIT = 1;
  localparam int unsigned CTRL_OVF_BIT  = 2;
  localparam int unsigned CTRL_CAPF_BIT = 3;
endpackage

// File: rtl/frt_sync_edge.sv
module frt_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic rise_sel,
  output logic pulse
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= 1'b0;
    else        chain[0] <= din;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[i] <= 1'b0;
      else        chain[i] <= chain[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= chain[STAGES-1];
  end

  assign pulse = rise_sel ? (chain[STAGES-1] & ~prev) : (~chain[STAGES-1] & prev);

  // R6 / R8: one qualifying edge never yields two adjacent pulses
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !(pulse && rise_sel == $past(rise_sel)));
endmodule

// File: rtl/frt_tick_sel.sv
module frt_tick_sel #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_sel,
  input  logic ext_pulse,
  input  logic restart,
  output logic tick
);
  localparam int unsigned PW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] presc;
  logic          presc_wrap;

  assign presc_wrap = (presc == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          presc <= '0;
    else if (restart)    presc <= '0;
    else if (presc_wrap) presc <= '0;
    else                 presc <= presc + 1'b1;
  end

  assign tick = ext_sel ? ext_pulse : presc_wrap;

  // R5: internal ticks are spaced by the divider (DIV >= 2)
  a_r5_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_sel && tick) |=> !(tick && !ext_sel));
endmodule

// File: rtl/frt_capture.sv
module frt_capture #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_evt,
  input  logic             flag_clr,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cap_val,
  output logic             cap_flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cap_val <= '0;
    else if (cap_evt) cap_val <= cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cap_flag <= 1'b0;
    else if (cap_evt)  cap_flag <= 1'b1;
    else if (flag_clr) cap_flag <= 1'b0;
  end

  // R8: an event leaves the flag set and the counter value held
  a_r8_capture_loads: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (cap_flag && cap_val == $past(cnt)));
  // R11: without an event the flag only falls on a clearing write
  a_r11_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_flag && !flag_clr) |=> cap_flag);
endmodule

// File: rtl/frt16_bytebus.sv
module frt16_bytebus #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned PRESC_DIV = 4,
  parameter int unsigned SYNC_STG  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ext_clk_pin,
  input  logic              cap_pin,
  output logic              cap_flag
);
  import frt_pkg::*;

  localparam int unsigned CNT_W = 2 * DATA_W;

  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  cap_val;
  logic [DATA_W-1:0] stage;
  logic              src_ext, edge_rise, ovf;
  logic              ext_pulse, cap_evt, tick, wrap;
  logic              wr_cnt_hi, wr_cnt_lo, wr_ctrl, rd_cnt_hi, rd_cap_hi;

  assign wr_cnt_hi = bus_wr && (bus_addr == REG_CNT_HI);
  assign wr_cnt_lo = bus_wr && (bus_addr == REG_CNT_LO);
  assign wr_ctrl   = bus_wr && (bus_addr == REG_CTRL);
  assign rd_cnt_hi = bus_rd && (bus_addr == REG_CNT_HI);
  assign rd_cap_hi = bus_rd && (bus_addr == REG_CAP_HI);

  frt_sync_edge #(.STAGES(SYNC_STG)) u_ext_sync (
    .clk(clk), .rst_n(rst_n), .din(ext_clk_pin), .rise_sel(1'b1), .pulse(ext_pulse)
  );

  frt_sync_edge #(.STAGES(SYNC_STG)) u_cap_sync (
    .clk(clk), .rst_n(rst_n), .din(cap_pin), .rise_sel(edge_rise), .pulse(cap_evt)
  );

  frt_tick_sel #(.DIV(PRESC_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .ext_sel(src_ext), .ext_pulse(ext_pulse),
    .restart(wr_cnt_lo), .tick(tick)
  );

  frt_capture #(.CNT_W(CNT_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .cap_evt(cap_evt),
    .flag_clr(wr_ctrl && !bus_wdata[CTRL_CAPF_BIT]),
    .cnt(cnt), .cap_val(cap_val), .cap_flag(cap_flag)
  );

  assign wrap = tick && !wr_cnt_lo && (cnt == {CNT_W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (wr_cnt_lo) cnt <= {stage, bus_wdata};
    else if (tick)      cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         stage <= '0;
    else if (wr_cnt_hi) stage <= bus_wdata;
    else if (rd_cnt_hi) stage <= cnt[DATA_W-1:0];
    else if (rd_cap_hi) stage <= cap_val[DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_ext   <= 1'b0;
      edge_rise <= 1'b0;
    end else if (wr_ctrl) begin
      src_ext   <= bus_wdata[CTRL_SRC_BIT];
      edge_rise <= bus_wdata[CTRL_EDGE_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   ovf <= 1'b0;
    else if (wrap)                                ovf <= 1'b1;
    else if (wr_ctrl && !bus_wdata[CTRL_OVF_BIT]) ovf <= 1'b0;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        REG_CNT_HI: bus_rdata = cnt[CNT_W-1:DATA_W];
        REG_CNT_LO: bus_rdata = stage;
        REG_CAP_HI: bus_rdata = cap_val[CNT_W-1:DATA_W];
        REG_CAP_LO: bus_rdata = stage;
        REG_CTRL: begin
          bus_rdata[CTRL_SRC_BIT]  = src_ext;
          bus_rdata[CTRL_EDGE_BIT] = edge_rise;
          bus_rdata[CTRL_OVF_BIT]  = ovf;
          bus_rdata[CTRL_CAPF_BIT] = cap_flag;
        end
        default: bus_rdata = '0;
      endcase
    end
  end

  // R2: an upper counter read snapshots the live lower half
  a_r2_hi_read_snap: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cnt_hi && !bus_wr) |=> stage == $past(cnt[DATA_W-1:0]));
  // R3: an upper write alone never moves the counter
  a_r3_hi_write_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cnt_hi && !tick) |=> $stable(cnt));
  // R4: a lower write loads all bits at once
  a_r4_lo_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt_lo |=> cnt == {$past(stage), $past(bus_wdata)});
  // R7: advance from all-ones lands on zero with overflow set
  a_r7_wrap_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_cnt_lo && cnt == {CNT_W{1'b1}}) |=> (cnt == '0 && ovf));
endmodule

// File: tb/frt16_bytebus_tb.sv
module frt16_bytebus_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic       ext_clk_pin = 1'b0;
  logic       cap_pin = 1'b0;
  logic       cap_flag;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] mon_data;
  event       mon_ev;

  always #4 clk = ~clk;

  frt16_bytebus u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .ext_clk_pin(ext_clk_pin), .cap_pin(cap_pin), .cap_flag(cap_flag)
  );

  initial begin
    forever begin
      @(mon_ev);
      begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (mon_data !== e) begin
          errors++;
          $display("FAIL %s: read 0x%02h expected 0x%02h", t, mon_data, e);
        end
      end
    end
  end

  task automatic rd_expect(input logic [2:0] a, input logic [7:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    bus_addr = a;
    bus_rd = 1'b1;
    #2;
    mon_data = bus_rdata;
    ->mon_ev;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    bus_wdata = d;
    bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic ext_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) ext_clk_pin = 1'b1;
      repeat (2) @(negedge clk);
      ext_clk_pin = 1'b0;
      repeat (2) @(negedge clk);
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic pin_check(input logic exp, input string t);
    checks++;
    if (cap_flag !== exp) begin
      errors++;
      $display("FAIL %s: cap_flag %0b expected %0b", t, cap_flag, exp);
    end
  endtask

  task automatic finish_run();
    #1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_expect(3'd4, 8'h00, "R1 control");
    pin_check(1'b0, "R1 cap_flag");
    rd_expect(3'd0, 8'h00, "R1 counter upper");
    rd_expect(3'd2, 8'h00, "R1 capture upper");
    rd_expect(3'd3, 8'h00, "R1 capture lower");

    // external source, counter frozen while the pin is idle
    wr(3'd4, 8'h01);
    wr(3'd0, 8'h12);
    wr(3'd1, 8'h34);
    rd_expect(3'd0, 8'h12, "R4 upper after load");
    rd_expect(3'd1, 8'h34, "R4 lower after load");
    wr(3'd0, 8'hAB);
    rd_expect(3'd0, 8'h12, "R3 upper write held");
    rd_expect(3'd1, 8'h34, "R3 lower after upper write");

    // R2: lower byte comes from the snapshot, not the live counter
    rd_expect(3'd0, 8'h12, "R2 upper snapshot");
    ext_pulses(3);
    rd_expect(3'd1, 8'h34, "R2 lower from staging");
    rd_expect(3'd0, 8'h12, "R6 upper after 3 pulses");
    rd_expect(3'd1, 8'h37, "R6 three pulses counted");
    repeat (10) @(negedge clk);
    rd_expect(3'd0, 8'h12, "R6 holds without pulses");
    rd_expect(3'd1, 8'h37, "R6 lower holds");

    // R7 wrap and overflow flag
    wr(3'd0, 8'hFF);
    wr(3'd1, 8'hFE);
    ext_pulses(2);
    rd_expect(3'd0, 8'h00, "R7 wrapped upper");
    rd_expect(3'd1, 8'h00, "R7 wrapped lower");
    rd_expect(3'd4, 8'h05, "R7 overflow set");
    wr(3'd4, 8'h05);
    rd_expect(3'd4, 8'h05, "R7 write 1 keeps overflow");
    wr(3'd4, 8'h01);
    rd_expect(3'd4, 8'h01, "R7 write 0 clears overflow");

    // R8 falling-edge capture, rising edge ignored
    wr(3'd0, 8'h43);
    wr(3'd1, 8'h21);
    @(negedge clk) cap_pin = 1'b1;
    repeat (6) @(negedge clk);
    pin_check(1'b0, "R8 opposite edge ignored");
    rd_expect(3'd2, 8'h00, "R8 no capture on opposite edge");
    @(negedge clk) cap_pin = 1'b0;
    repeat (6) @(negedge clk);
    pin_check(1'b1, "R8 falling edge flag");
    rd_expect(3'd2, 8'h43, "R9 capture upper");
    rd_expect(3'd3, 8'h21, "R9 capture lower via staging");
    rd_expect(3'd4, 8'h09, "R8 flag in control");
    wr(3'd4, 8'h09);
    pin_check(1'b1, "R11 write 1 keeps flag");
    wr(3'd4, 8'h01);
    pin_check(1'b0, "R11 write 0 clears flag");

    // R8 rising-edge capture
    wr(3'd4, 8'h03);
    wr(3'd0, 8'h5A);
    wr(3'd1, 8'hA5);
    @(negedge clk) cap_pin = 1'b1;
    repeat (6) @(negedge clk);
    pin_check(1'b1, "R8 rising edge flag");
    rd_expect(3'd2, 8'h5A, "R8 rising capture upper");
    rd_expect(3'd3, 8'hA5, "R8 rising capture lower");

    // R10 capture register is read-only
    wr(3'd2, 8'hFF);
    wr(3'd3, 8'hEE);
    rd_expect(3'd2, 8'h5A, "R10 capture upper unchanged");
    rd_expect(3'd3, 8'hA5, "R10 capture lower unchanged");

    // R5 internal divider: K + 10 exactly 40 clocks after the load edge
    wr(3'd4, 8'h00);
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h00);
    repeat (39) @(negedge clk);
    rd_expect(3'd0, 8'h00, "R5 upper after 40 clocks");
    rd_expect(3'd1, 8'h0A, "R5 ten ticks in 40 clocks");

    repeat (4) @(negedge clk);
    finished = 1'b1;
    finish_run();
  end
endmodule